// File: doc/BRIEF.md
# Dual-Request Configurable Interrupt Controller

This block gathers up to 32 interrupt inputs and presents them to a processor on two request lines and one wake line. Each input has its own sensitivity setting. It can be disabled, rising-edge, falling-edge, either-edge, high-level or low-level. Each input also has a routing bit that picks one of the two request lines, a mask bit that lets it through, and a wake-enable bit. Edge detections are held in per-input latches until software clears them.

Software reaches the block over a plain word-addressed register bus. A write strobe takes effect on the next clock edge, and read data follows the address without any clock. Every configuration plane has three addresses. One sets the bits written as one, one clears the bits written as one, and one reads the stored value. Zero bits in a write leave their positions unchanged. Software can read the raw edge latches and the two pending vectors, and uses those vectors to find which inputs need service on each request line.

Top module: `dual_req_intc`

## Requirements
- R1: After reset every plane, latch, test word and pending vector reads zero, and req0_o, req1_o and wake_o are low.
- R2: Plane k (sens0=0, sens1=1, sens2=2, origin=3, route=4, wake=5, mask=6) has its set address at 4k, its clear address at 4k+1 and its read address at 4k+2. On a set write the written ones become one, on a clear write they become zero, and zero bits in the write change nothing.
- R3: The sensitivity code of input i is {sens2[i], sens1[i], sens0[i]}. Code 001 latches rising edges, 010 latches falling edges and 011 latches both. The rising latches read at address 28 and the falling latches at address 29.
- R4: Code 101 makes an input active while it is high, and code 110 makes it active while it is low. Neither code sets an edge latch.
- R5: Codes 000, 100 and 111 are disabled. Such an input sets no latch and never appears in a pending vector, whatever it does.
- R6: An edge latch holds until a one is written to its bit at address 28 (rising) or 29 (falling). If a new edge arrives in the same cycle as the clear, the latch stays set.
- R7: An input appears in a pending vector only while its mask bit is one. A clear mask bit keeps the edge latch intact, so setting the mask later exposes the held event.
- R8: Pending vector 0 (read at 32) holds the active, unmasked inputs whose route bit is one. Pending vector 1 (read at 33) holds those whose route bit is zero. req0_o and req1_o are the OR of the respective vector, one cycle later.
- R9: wake_o goes high one cycle after any active input has its wake bit set, whatever its mask and route bits.
- R10: An input change sampled at clock edge k shows in a pending vector after edge k+2 in an edge mode and after edge k+1 in a level mode.
- R11: The origin plane and the test word (written and read whole at address 30) store their values and read them back, and they have no effect on any request or wake output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Raw interrupt inputs, asynchronous |
| bus_wr | input | 1 | Write strobe, applied at the clock edge |
| bus_addr | input | ADDR_W | Word address for reads and writes |
| bus_wdata | input | NSRC | Write data, one bit per input |
| bus_rdata | output | NSRC | Read data for bus_addr, combinational |
| req0_o | output | 1 | Request line 0 |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
Faults in the internal state show up at the ports quickly. A latch that is stuck, set without its edge mode, or cleared by the wrong write shows in the address 28/29 read and in a pending vector on the cycle after the fault. The matching request line follows one cycle later. A wrong routing or mask bit sends an input to the wrong pending vector, or to none, so the bench checks both vectors and both request lines for each scenario. A synchronizer depth that is off by one moves the first pending cycle, and the bench catches this by sampling the request line in the cycle before it is due to rise as well as in the cycle it rises.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // configuration planes, in address order
  localparam int PLANES   = 7;
  localparam int P_SENS0  = 0;
  localparam int P_SENS1  = 1;
  localparam int P_SENS2  = 2;
  localparam int P_ORIGIN = 3;
  localparam int P_ROUTE  = 4;
  localparam int P_WAKE   = 5;
  localparam int P_MASK   = 6;

  // single-word addresses
  localparam int ADDR_RISE  = 28;
  localparam int ADDR_FALL  = 29;
  localparam int ADDR_DIAG  = 30;
  localparam int ADDR_PEND0 = 32;
  localparam int ADDR_PEND1 = 33;

  function automatic int plane_set_addr(input int p);
    return p * 4;
  endfunction

  function automatic int plane_clr_addr(input int p);
    return p * 4 + 1;
  endfunction

  function automatic int plane_rd_addr(input int p);
    return p * 4 + 2;
  endfunction

  // sensitivity code is {sens2, sens1, sens0}
  function automatic logic takes_rise(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b011);
  endfunction

  function automatic logic takes_fall(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic level_high(input logic [2:0] code);
    return code == 3'b101;
  endfunction

  function automatic logic level_low(input logic [2:0] code);
    return code == 3'b110;
  endfunction

endpackage

// File: rtl/intc_regfile.sv
module intc_regfile
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  input  logic [NSRC-1:0]   rise_lat_i,
  input  logic [NSRC-1:0]   fall_lat_i,
  input  logic [NSRC-1:0]   pend0_i,
  input  logic [NSRC-1:0]   pend1_i,
  output logic [NSRC-1:0]   sens0_o,
  output logic [NSRC-1:0]   sens1_o,
  output logic [NSRC-1:0]   sens2_o,
  output logic [NSRC-1:0]   route_o,
  output logic [NSRC-1:0]   wake_en_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [NSRC-1:0]   rise_clr_o,
  output logic [NSRC-1:0]   fall_clr_o,
  output logic [NSRC-1:0]   bus_rdata_o
);

  logic [PLANES-1:0][NSRC-1:0] plane_v;
  logic [NSRC-1:0]             diag_q;

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    logic            hit_set;
    logic            hit_clr;
    logic [NSRC-1:0] q;

    assign hit_set = bus_wr && (bus_addr == ADDR_W'(plane_set_addr(p)));
    assign hit_clr = bus_wr && (bus_addr == ADDR_W'(plane_clr_addr(p)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (hit_set) q <= q | bus_wdata;
      else if (hit_clr) q <= q & ~bus_wdata;
    end

    assign plane_v[p] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) diag_q <= '0;
    else if (bus_wr && (bus_addr == ADDR_W'(ADDR_DIAG))) diag_q <= bus_wdata;
  end

  // write-one-to-clear pulses toward the edge latches
  assign rise_clr_o = (bus_wr && (bus_addr == ADDR_W'(ADDR_RISE))) ? bus_wdata : '0;
  assign fall_clr_o = (bus_wr && (bus_addr == ADDR_W'(ADDR_FALL))) ? bus_wdata : '0;

  assign sens0_o   = plane_v[P_SENS0];
  assign sens1_o   = plane_v[P_SENS1];
  assign sens2_o   = plane_v[P_SENS2];
  assign route_o   = plane_v[P_ROUTE];
  assign wake_en_o = plane_v[P_WAKE];
  assign mask_o    = plane_v[P_MASK];

  always_comb begin
    bus_rdata_o = '0;
    for (int p = 0; p < PLANES; p++) begin
      if (bus_addr == ADDR_W'(plane_rd_addr(p))) bus_rdata_o = plane_v[p];
    end
    if (bus_addr == ADDR_W'(ADDR_RISE))  bus_rdata_o = rise_lat_i;
    if (bus_addr == ADDR_W'(ADDR_FALL))  bus_rdata_o = fall_lat_i;
    if (bus_addr == ADDR_W'(ADDR_DIAG))  bus_rdata_o = diag_q;
    if (bus_addr == ADDR_W'(ADDR_PEND0)) bus_rdata_o = pend0_i;
    if (bus_addr == ADDR_W'(ADDR_PEND1)) bus_rdata_o = pend1_i;
  end

endmodule

// File: rtl/intc_edge_bank.sv
module intc_edge_bank
  import intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] sens0_i,
  input  logic [NSRC-1:0] sens1_i,
  input  logic [NSRC-1:0] sens2_i,
  input  logic [NSRC-1:0] rise_clr_i,
  input  logic [NSRC-1:0] fall_clr_i,
  output logic [NSRC-1:0] sync_o,
  output logic [NSRC-1:0] rise_arm_o,
  output logic [NSRC-1:0] fall_arm_o,
  output logic [NSRC-1:0] rise_lat_o,
  output logic [NSRC-1:0] fall_lat_o
);

  logic [NSRC-1:0] meta_q, sync_q, prev_q;
  logic [NSRC-1:0] rise_q, fall_q;
  logic [NSRC-1:0] rise_evt, fall_evt;

  for (genvar i = 0; i < NSRC; i++) begin : g_arm
    logic [2:0] code;
    assign code          = {sens2_i[i], sens1_i[i], sens0_i[i]};
    assign rise_arm_o[i] = takes_rise(code);
    assign fall_arm_o[i] = takes_fall(code);
  end

  assign rise_evt = sync_q & ~prev_q;
  assign fall_evt = ~sync_q & prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      meta_q <= src_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      // a fresh event beats a clear in the same cycle
      rise_q <= (rise_q & ~rise_clr_i) | (rise_evt & rise_arm_o);
      fall_q <= (fall_q & ~fall_clr_i) | (fall_evt & fall_arm_o);
    end
  end

  assign sync_o     = sync_q;
  assign rise_lat_o = rise_q;
  assign fall_lat_o = fall_q;

endmodule

// File: rtl/intc_route_stage.sv
module intc_route_stage
  import intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] sync_i,
  input  logic [NSRC-1:0] rise_lat_i,
  input  logic [NSRC-1:0] fall_lat_i,
  input  logic [NSRC-1:0] sens0_i,
  input  logic [NSRC-1:0] sens1_i,
  input  logic [NSRC-1:0] sens2_i,
  input  logic [NSRC-1:0] mask_i,
  input  logic [NSRC-1:0] route_i,
  input  logic [NSRC-1:0] wake_en_i,
  output logic [NSRC-1:0] active_o,
  output logic [NSRC-1:0] pend0_o,
  output logic [NSRC-1:0] pend1_o,
  output logic            req0_o,
  output logic            req1_o,
  output logic            wake_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_act
    logic [2:0] code;
    assign code = {sens2_i[i], sens1_i[i], sens0_i[i]};
    assign active_o[i] = (rise_lat_i[i] &  takes_rise(code))
                       | (fall_lat_i[i] &  takes_fall(code))
                       | (sync_i[i]     &  level_high(code))
                       | (~sync_i[i]    &  level_low(code));
  end

  assign pend0_o = active_o & mask_i &  route_i;
  assign pend1_o = active_o & mask_i & ~route_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req0_o <= 1'b0;
      req1_o <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      req0_o <= |pend0_o;
      req1_o <= |pend1_o;
      wake_o <= |(active_o & wake_en_i);
    end
  end

endmodule

// File: rtl/dual_req_intc.sv
module dual_req_intc
  import intc_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);

  logic [NSRC-1:0] sens0_v, sens1_v, sens2_v;
  logic [NSRC-1:0] route_v, wake_en_v, mask_v;
  logic [NSRC-1:0] rise_clr_v, fall_clr_v;
  logic [NSRC-1:0] sync_v, rise_arm_v, fall_arm_v;
  logic [NSRC-1:0] rise_lat_v, fall_lat_v;
  logic [NSRC-1:0] active_v, pend0_v, pend1_v;

  intc_regfile #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rise_lat_i  (rise_lat_v),
    .fall_lat_i  (fall_lat_v),
    .pend0_i     (pend0_v),
    .pend1_i     (pend1_v),
    .sens0_o     (sens0_v),
    .sens1_o     (sens1_v),
    .sens2_o     (sens2_v),
    .route_o     (route_v),
    .wake_en_o   (wake_en_v),
    .mask_o      (mask_v),
    .rise_clr_o  (rise_clr_v),
    .fall_clr_o  (fall_clr_v),
    .bus_rdata_o (bus_rdata)
  );

  intc_edge_bank #(.NSRC(NSRC)) u_edges (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (irq_src),
    .sens0_i    (sens0_v),
    .sens1_i    (sens1_v),
    .sens2_i    (sens2_v),
    .rise_clr_i (rise_clr_v),
    .fall_clr_i (fall_clr_v),
    .sync_o     (sync_v),
    .rise_arm_o (rise_arm_v),
    .fall_arm_o (fall_arm_v),
    .rise_lat_o (rise_lat_v),
    .fall_lat_o (fall_lat_v)
  );

  intc_route_stage #(.NSRC(NSRC)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_i     (sync_v),
    .rise_lat_i (rise_lat_v),
    .fall_lat_i (fall_lat_v),
    .sens0_i    (sens0_v),
    .sens1_i    (sens1_v),
    .sens2_i    (sens2_v),
    .mask_i     (mask_v),
    .route_i    (route_v),
    .wake_en_i  (wake_en_v),
    .active_o   (active_v),
    .pend0_o    (pend0_v),
    .pend1_o    (pend1_v),
    .req0_o     (req0_o),
    .req1_o     (req1_o),
    .wake_o     (wake_o)
  );

endmodule

// File: rtl/dual_req_intc_chk.sv
module dual_req_intc_chk #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] pend0,
  input logic [NSRC-1:0] pend1,
  input logic            req0,
  input logic            req1,
  input logic            wake,
  input logic [NSRC-1:0] active,
  input logic [NSRC-1:0] wake_en,
  input logic [NSRC-1:0] rise_lat,
  input logic [NSRC-1:0] fall_lat,
  input logic [NSRC-1:0] rise_clr,
  input logic [NSRC-1:0] fall_clr,
  input logic [NSRC-1:0] rise_arm,
  input logic [NSRC-1:0] fall_arm
);

  p_mask_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 | pend1) & ~mask) == '0);

  p_route_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0);

  p_req0_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend0) |=> req0);

  p_req0_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend0) |=> !req0);

  p_req1_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend1) |=> req1);

  p_req1_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|pend1) |=> !req1);

  p_wake_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(active & wake_en)) |=> wake);

  p_rise_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rise_lat) & ~rise_lat & ~$past(rise_clr)) == '0);

  p_fall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fall_lat) & ~fall_lat & ~$past(fall_clr)) == '0);

  p_rise_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_lat & ~$past(rise_lat) & ~$past(rise_arm)) == '0);

  p_fall_armed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_lat & ~$past(fall_lat) & ~$past(fall_arm)) == '0);

endmodule

bind dual_req_intc dual_req_intc_chk #(.NSRC(NSRC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mask     (mask_v),
  .pend0    (pend0_v),
  .pend1    (pend1_v),
  .req0     (req0_o),
  .req1     (req1_o),
  .wake     (wake_o),
  .active   (active_v),
  .wake_en  (wake_en_v),
  .rise_lat (rise_lat_v),
  .fall_lat (fall_lat_v),
  .rise_clr (rise_clr_v),
  .fall_clr (fall_clr_v),
  .rise_arm (rise_arm_v),
  .fall_arm (fall_arm_v)
);

// File: tb/dual_req_intc_tb_top.sv
module dual_req_intc_tb_top;

  // addresses restated from the requirements (R2, R3, R8, R11)
  localparam logic [5:0] A_S0_SET = 6'd0,  A_S0_CLR = 6'd1;
  localparam logic [5:0] A_S1_SET = 6'd4,  A_S1_CLR = 6'd5;
  localparam logic [5:0] A_S2_SET = 6'd8,  A_S2_CLR = 6'd9;
  localparam logic [5:0] A_OR_SET = 6'd12, A_OR_RD  = 6'd14;
  localparam logic [5:0] A_RT_SET = 6'd16, A_RT_CLR = 6'd17;
  localparam logic [5:0] A_WK_SET = 6'd20, A_WK_CLR = 6'd21;
  localparam logic [5:0] A_MK_SET = 6'd24, A_MK_CLR = 6'd25, A_MK_RD = 6'd26;
  localparam logic [5:0] A_RISE = 6'd28, A_FALL = 6'd29, A_DIAG = 6'd30;
  localparam logic [5:0] A_PEND0 = 6'd32, A_PEND1 = 6'd33;

  localparam int K_READ = 0, K_REQ0 = 1, K_REQ1 = 2, K_WAKE = 3;

  typedef struct {
    int          kind;
    logic [5:0]  addr;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        req0, req1, wake;

  sb_item_t sb_q[$];
  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_req_intc dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_src   (src),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req0_o    (req0),
    .req1_o    (req1),
    .wake_o    (wake)
  );

  // ---------------- driver tasks ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic chk_rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    sb_item_t it;
    bus_addr = a;
    it.kind = K_READ; it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  task automatic chk_pin(input int k, input logic e, input string tag);
    sb_item_t it;
    it.kind = k; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // ---------------- monitor ----------------
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        sb_item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_REQ0:  act = {31'd0, req0};
          K_REQ1:  act = {31'd0, req1};
          K_WAKE:  act = {31'd0, wake};
          default: act = bus_rdata;
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    tick(3);
    rst_n = 1'b1;

    // R1: reset state
    chk_pin(K_REQ0, 1'b0, "R1 req0 reset");
    chk_pin(K_REQ1, 1'b0, "R1 req1 reset");
    chk_pin(K_WAKE, 1'b0, "R1 wake reset");
    for (int p = 0; p < 7; p++) chk_rd(6'(p * 4 + 2), 32'h0, "R1 plane reset");
    chk_rd(A_RISE, 32'h0, "R1 rise latch reset");
    chk_rd(A_FALL, 32'h0, "R1 fall latch reset");
    chk_rd(A_DIAG, 32'h0, "R1 test word reset");
    chk_rd(A_PEND0, 32'h0, "R1 pend0 reset");
    chk_rd(A_PEND1, 32'h0, "R1 pend1 reset");

    // R2: set / clear / readback
    wr(A_MK_SET, 32'h0000_00F0);
    chk_rd(A_MK_RD, 32'h0000_00F0, "R2 set write");
    wr(A_MK_SET, 32'h0000_0003);
    chk_rd(A_MK_RD, 32'h0000_00F3, "R2 set keeps zeros");
    wr(A_MK_CLR, 32'h0000_0030);
    chk_rd(A_MK_RD, 32'h0000_00C3, "R2 clear write");
    wr(A_MK_CLR, 32'hFFFF_FFFF);
    chk_rd(A_MK_RD, 32'h0, "R2 clear all");

    // R3 / R10: rising edge on src0, routed to req0
    wr(A_S0_SET, 32'h1);
    wr(A_RT_SET, 32'h1);
    wr(A_MK_SET, 32'h1);
    src[0] = 1'b1;
    tick(3);
    chk_pin(K_REQ0, 1'b0, "R10 req0 not yet");
    chk_rd(A_PEND0, 32'h1, "R10 edge pending after k+2");
    chk_pin(K_REQ0, 1'b1, "R8 req0 asserted");
    chk_rd(A_RISE, 32'h1, "R3 rise latched");
    chk_rd(A_PEND1, 32'h0, "R8 not on pend1");
    chk_pin(K_REQ1, 1'b0, "R8 req1 idle");
    src[0] = 1'b0;
    tick(4);
    chk_rd(A_FALL, 32'h0, "R3 rise mode ignores fall");
    chk_rd(A_PEND0, 32'h1, "R6 latch holds after input drops");
    wr(A_RISE, 32'h0);
    chk_rd(A_RISE, 32'h1, "R6 zero write keeps latch");
    wr(A_RISE, 32'h1);
    chk_rd(A_PEND0, 32'h0, "R6 clear removes pending");
    chk_pin(K_REQ0, 1'b0, "R6 req0 drops");
    wr(A_MK_CLR, 32'h1);

    // R7: masked rising edge on src1, routed to req1
    wr(A_S0_SET, 32'h2);
    src[1] = 1'b1;
    tick(4);
    chk_rd(A_RISE, 32'h2, "R7 latched while masked");
    chk_rd(A_PEND1, 32'h0, "R7 masked not pending");
    chk_pin(K_REQ1, 1'b0, "R7 masked no req1");
    wr(A_MK_SET, 32'h2);
    chk_rd(A_PEND1, 32'h2, "R7 unmask exposes event");
    chk_pin(K_REQ1, 1'b1, "R8 req1 asserted");
    chk_rd(A_PEND0, 32'h0, "R8 route zero stays off pend0");
    wr(A_MK_CLR, 32'h2);
    wr(A_RISE, 32'h2);

    // R3: falling edge on src2
    wr(A_S1_SET, 32'h4);
    wr(A_RT_SET, 32'h4);
    wr(A_MK_SET, 32'h4);
    src[2] = 1'b1;
    tick(4);
    chk_rd(A_RISE, 32'h0, "R3 fall mode ignores rise");
    src[2] = 1'b0;
    tick(3);
    chk_rd(A_FALL, 32'h4, "R3 fall latched");
    chk_rd(A_PEND0, 32'h4, "R3 fall pending");
    wr(A_FALL, 32'h4);
    chk_rd(A_PEND0, 32'h0, "R6 fall clear");
    wr(A_MK_CLR, 32'h4);
    wr(A_S1_CLR, 32'h4);

    // R3: both edges on src3
    wr(A_S0_SET, 32'h8);
    wr(A_S1_SET, 32'h8);
    wr(A_RT_SET, 32'h8);
    wr(A_MK_SET, 32'h8);
    src[3] = 1'b1;
    tick(4);
    chk_rd(A_RISE, 32'h8, "R3 both mode rise");
    chk_rd(A_FALL, 32'h0, "R3 both mode no fall yet");
    chk_rd(A_PEND0, 32'h8, "R3 both mode pending");
    wr(A_RISE, 32'h8);
    chk_rd(A_PEND0, 32'h0, "R6 both rise cleared");
    src[3] = 1'b0;
    tick(4);
    chk_rd(A_FALL, 32'h8, "R3 both mode fall");
    chk_rd(A_PEND0, 32'h8, "R3 both mode fall pending");
    wr(A_FALL, 32'h8);
    chk_rd(A_PEND0, 32'h0, "R6 both fall cleared");
    wr(A_MK_CLR, 32'h8);

    // R4 / R10: high level on src4, routed to req1
    wr(A_S2_SET, 32'h10);
    wr(A_S0_SET, 32'h10);
    wr(A_MK_SET, 32'h10);
    chk_rd(A_PEND1, 32'h0, "R4 high level idle");
    src[4] = 1'b1;
    tick(2);
    chk_pin(K_REQ1, 1'b0, "R10 level req1 not yet");
    chk_rd(A_PEND1, 32'h10, "R10 level pending after k+1");
    chk_pin(K_REQ1, 1'b1, "R4 high level req1");
    chk_rd(A_RISE, 32'h0, "R4 level sets no latch");
    src[4] = 1'b0;
    tick(2);
    chk_rd(A_PEND1, 32'h0, "R4 high level released");
    chk_pin(K_REQ1, 1'b0, "R4 req1 released");

    // R9: wake with mask clear
    wr(A_MK_CLR, 32'h10);
    wr(A_WK_SET, 32'h10);
    src[4] = 1'b1;
    tick(3);
    chk_pin(K_WAKE, 1'b1, "R9 wake asserted");
    chk_pin(K_REQ1, 1'b0, "R9 masked no request");
    chk_rd(A_PEND1, 32'h0, "R9 masked not pending");
    src[4] = 1'b0;
    tick(3);
    chk_pin(K_WAKE, 1'b0, "R9 wake released");
    wr(A_WK_CLR, 32'h10);
    wr(A_S2_CLR, 32'h10);
    wr(A_S0_CLR, 32'h10);

    // R4: low level on src5, routed to req0
    wr(A_S2_SET, 32'h20);
    wr(A_S1_SET, 32'h20);
    wr(A_RT_SET, 32'h20);
    wr(A_MK_SET, 32'h20);
    chk_rd(A_PEND0, 32'h20, "R4 low level active on low input");
    chk_pin(K_REQ0, 1'b1, "R4 low level req0");
    src[5] = 1'b1;
    tick(3);
    chk_pin(K_REQ0, 1'b0, "R4 low level req0 released");
    chk_rd(A_PEND0, 32'h0, "R4 low level released");
    wr(A_MK_CLR, 32'h20);
    wr(A_S2_CLR, 32'h20);
    wr(A_S1_CLR, 32'h20);

    // R5: codes 100 (src6), 111 (src7), 000 (src8)
    wr(A_S2_SET, 32'h0C0);
    wr(A_S1_SET, 32'h080);
    wr(A_S0_SET, 32'h080);
    wr(A_RT_SET, 32'h1C0);
    wr(A_MK_SET, 32'h1C0);
    wr(A_RT_CLR, 32'h0);
    chk_rd(A_PEND0, 32'h0, "R5 disabled idle");
    src[8:6] = 3'b111;
    tick(4);
    chk_rd(A_PEND0, 32'h0, "R5 disabled ignore high");
    chk_rd(A_RISE, 32'h0, "R5 disabled no rise latch");
    chk_pin(K_REQ0, 1'b0, "R5 disabled no req0");
    src[8:6] = 3'b000;
    tick(4);
    chk_rd(A_FALL, 32'h0, "R5 disabled no fall latch");
    chk_rd(A_PEND0, 32'h0, "R5 disabled ignore low");

    // R11: origin plane and test word
    wr(A_OR_SET, 32'hA5A5_0000);
    chk_rd(A_OR_RD, 32'hA5A5_0000, "R11 origin readback");
    wr(A_DIAG, 32'h1234_5678);
    chk_rd(A_DIAG, 32'h1234_5678, "R11 test word readback");
    chk_pin(K_REQ0, 1'b0, "R11 no req0 effect");
    chk_pin(K_REQ1, 1'b0, "R11 no req1 effect");
    chk_pin(K_WAKE, 1'b0, "R11 no wake effect");
    wr(A_DIAG, 32'h0);
    chk_rd(A_PEND1, 32'h0, "R11 no pend1 effect");

    tick(2);
    while (sb_q.size() > 0) tick(1);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule